// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sits beside a small microcontroller core and decides which clocks run. Software writes a power-control register carrying two request bits, one for idle and one for power-down. In idle the CPU clock is gated off while the peripheral clock and the oscillator keep running, so any enabled interrupt can bring the core back. In power-down the oscillator enable is dropped as well, and only the hardware reset pin can leave that state. Interrupts are ignored there.

The hardware reset pin is qualified by a counter. The internal reset asserts only after the pin has been sampled high on two full machine cycles of consecutive oscillator clocks. Shorter pulses leave the block untouched. When the internal reset fires, the mode bits return to zero and the core restarts in the running state. This models the register reinitialisation, while on-chip RAM is not touched. While a reset pin assertion is ending idle, the CPU clock runs again but CPU access to on-chip RAM is blocked, so no instruction executed in that window can corrupt memory. Port access stays allowed.

The states are RUN, IDLE, IDLE_RST (idle with the reset pin held, still being qualified), PDOWN and RESET (internal reset active). The transitions are:
- RUN to IDLE or PDOWN on a register write.
- IDLE to RUN on an interrupt.
- IDLE to IDLE_RST on the pin.
- IDLE_RST back to IDLE on a short pulse.
- RUN, IDLE_RST or PDOWN to RESET on a qualified pin.
- RESET to RUN when the pin is released.

The clock input is a free-running timebase. The oscillator enable output is what the block asks of the oscillator circuit.

Top module: `lpm_ctrl`

## Requirements
- R1: After `rst_n` is released the block is in RUN: `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1, while `int_rst`, `ram_block`, `wake`, `idle_bit` and `pd_bit` are 0.
- R2: In RUN, a register write with `wr_idle`=1 and `wr_pd`=0 moves the block to IDLE from the next cycle on. In IDLE, `cpu_clk_en`=0, `periph_clk_en`=1, `osc_en`=1 and `idle_bit`=1.
- R3: In RUN, a register write with `wr_pd`=1 moves the block to PDOWN from the next cycle on. In PDOWN all three clock enables are 0 and `pd_bit`=1. When both request bits are 1 together, power-down wins and `idle_bit` stays 0.
- R4: In IDLE, a high `irq_pending` sampled while `ext_rst` is 0 returns the block to RUN on the next cycle. At that point `idle_bit` is cleared and `wake` is 1 for exactly one cycle.
- R5: In PDOWN, `irq_pending` has no effect: all clock enables stay 0 and `pd_bit` stays 1.
- R6: With `MC_CLKS` clocks per machine cycle and `RST_MCS` machine cycles (defaults 12 and 2, giving 24), `int_rst` becomes 1 right after the edge that samples `ext_rst` high for the `MC_CLKS*RST_MCS`-th consecutive time. Any low sample restarts the count, so shorter pulses have no effect.
- R7: `int_rst` stays 1 while `ext_rst` stays high. The first edge that samples `ext_rst` low returns the block to RUN. While `int_rst` is 1, `idle_bit` and `pd_bit` read 0.
- R8: A qualified reset in PDOWN raises `int_rst` and restores `osc_en`=1. A shorter pulse leaves the block in PDOWN.
- R9: In IDLE, an `ext_rst` sample of 1 makes `ram_block`=1 and `cpu_clk_en`=1 from the next cycle on, while `periph_clk_en` stays 1. `irq_pending` is ignored while the pin is held. If the pulse ends before it qualifies, the block returns to IDLE with `ram_block`=0 and `cpu_clk_en`=0.
- R10: Register writes outside RUN are ignored: a write with `wr_idle`=1 in PDOWN leaves `pd_bit`=1, `idle_bit`=0 and the clocks off.
- R11: `ram_block` is 1 whenever `int_rst` is 1, and 0 in RUN, IDLE and PDOWN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase (oscillator clock) |
| rst_n | input | 1 | Asynchronous active-low initialisation of the block's flops |
| pcon_we | input | 1 | Write strobe of the power-control register |
| wr_idle | input | 1 | Idle request bit of the write |
| wr_pd | input | 1 | Power-down request bit of the write |
| irq_pending | input | 1 | Any enabled interrupt request |
| ext_rst | input | 1 | Hardware reset pin, active high |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator run enable |
| int_rst | output | 1 | Qualified internal reset |
| ram_block | output | 1 | Blocks CPU access to on-chip RAM |
| wake | output | 1 | One-cycle strobe on interrupt exit from idle |
| idle_bit | output | 1 | Idle bit of the power-control register |
| pd_bit | output | 1 | Power-down bit of the power-control register |

## Verification
The bench builds the block with `MC_CLKS`=4 and `RST_MCS`=2, which gives an eight-clock qualification window. With so short a window, every reset pulse length from 1 to 10 clocks can be swept from each of RUN, IDLE and PDOWN. That covers the lengths just below, exactly at and beyond the threshold in every resting state. The expected value of `int_rst` at each clock is computed from the count of high samples. Two sub-threshold pulses separated by a single low cycle check that the counter restarts.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_IDLE     = 3'd1,
        ST_IDLE_RST = 3'd2,
        ST_PDOWN    = 3'd3,
        ST_RESET    = 3'd4
    } lpm_state_e;

    typedef struct packed {
        logic cpu;
        logic periph;
        logic osc;
    } lpm_clk_en_t;

endpackage

// File: rtl/lpm_rst_filter.sv
module lpm_rst_filter #(
    parameter int MC_CLKS = 12,
    parameter int RST_MCS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_rst,
    output logic rst_done
);
    localparam int RST_CLKS = MC_CLKS * RST_MCS;
    localparam int CW       = (RST_CLKS > 2) ? $clog2(RST_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CLKS - 1);

    logic [CW-1:0] cnt;
    logic          at_last;

    assign at_last = (cnt == LAST);

    // Counts consecutive high samples; any low sample restarts the window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!ext_rst) begin
            cnt <= '0;
        end else if (!at_last) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The edge that sees the pin high with LAST earlier high samples is the qualifying one.
    assign rst_done = ext_rst && at_last;

    a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    a_r6_done_follows_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $past(ext_rst));

endmodule

// File: rtl/lpm_mode_reg.sv
module lpm_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_idle,
    input  logic set_pd,
    input  logic clr_idle,
    input  logic clr_all,
    output logic idle_bit,
    output logic pd_bit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_bit <= 1'b0;
            pd_bit   <= 1'b0;
        end else if (clr_all) begin
            idle_bit <= 1'b0;
            pd_bit   <= 1'b0;
        end else if (set_pd) begin
            idle_bit <= 1'b0;
            pd_bit   <= 1'b1;
        end else if (set_idle) begin
            idle_bit <= 1'b1;
        end else if (clr_idle) begin
            idle_bit <= 1'b0;
        end
    end

    a_r3_bits_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({idle_bit, pd_bit}));

    a_r4_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_idle && !clr_all && !set_pd && !set_idle) |=> !idle_bit);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pcon_we,
    input  logic        wr_idle,
    input  logic        wr_pd,
    input  logic        irq_pending,
    input  logic        ext_rst,
    input  logic        rst_done,
    output lpm_clk_en_t clk_en,
    output logic        int_rst,
    output logic        ram_block,
    output logic        wake,
    output logic        set_idle,
    output logic        set_pd,
    output logic        clr_idle,
    output logic        clr_all
);
    lpm_state_e state, state_nx;

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (rst_done)                 state_nx = ST_RESET;
                else if (pcon_we && wr_pd)    state_nx = ST_PDOWN;
                else if (pcon_we && wr_idle)  state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (rst_done)                 state_nx = ST_RESET;
                else if (ext_rst)             state_nx = ST_IDLE_RST;
                else if (irq_pending)         state_nx = ST_RUN;
            end
            ST_IDLE_RST: begin
                if (rst_done)                 state_nx = ST_RESET;
                else if (!ext_rst)            state_nx = ST_IDLE;
            end
            ST_PDOWN: begin
                if (rst_done)                 state_nx = ST_RESET;
            end
            ST_RESET: begin
                if (!ext_rst)                 state_nx = ST_RUN;
            end
            default:                          state_nx = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            wake  <= 1'b0;
        end else begin
            state <= state_nx;
            wake  <= (state == ST_IDLE) && (state_nx == ST_RUN);
        end
    end

    // Per-state outputs.
    always_comb begin
        clk_en    = '{cpu: 1'b1, periph: 1'b1, osc: 1'b1};
        int_rst   = 1'b0;
        ram_block = 1'b0;
        unique case (state)
            ST_RUN: ;
            ST_IDLE: begin
                clk_en.cpu = 1'b0;
            end
            ST_IDLE_RST: begin
                ram_block = 1'b1;
            end
            ST_PDOWN: begin
                clk_en = '{cpu: 1'b0, periph: 1'b0, osc: 1'b0};
            end
            ST_RESET: begin
                int_rst   = 1'b1;
                ram_block = 1'b1;
            end
            default: ;
        endcase
    end

    // Strobes for the mode register.
    assign set_idle = (state == ST_RUN)  && (state_nx == ST_IDLE);
    assign set_pd   = (state == ST_RUN)  && (state_nx == ST_PDOWN);
    assign clr_idle = (state == ST_IDLE) && (state_nx == ST_RUN);
    assign clr_all  = (state_nx == ST_RESET);

    a_r6_reset_needs_filter: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_rst) |-> $past(rst_done));

    a_r7_release_on_low_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_rst) |-> !$past(ext_rst));

    a_r9_hold_blocks_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ext_rst) |=> ram_block);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int MC_CLKS = 12,
    parameter int RST_MCS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pcon_we,
    input  logic wr_idle,
    input  logic wr_pd,
    input  logic irq_pending,
    input  logic ext_rst,
    output logic cpu_clk_en,
    output logic periph_clk_en,
    output logic osc_en,
    output logic int_rst,
    output logic ram_block,
    output logic wake,
    output logic idle_bit,
    output logic pd_bit
);
    logic        rst_done;
    logic        set_idle, set_pd, clr_idle, clr_all;
    lpm_clk_en_t clk_en;

    lpm_rst_filter #(
        .MC_CLKS (MC_CLKS),
        .RST_MCS (RST_MCS)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_rst  (ext_rst),
        .rst_done (rst_done)
    );

    lpm_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pcon_we     (pcon_we),
        .wr_idle     (wr_idle),
        .wr_pd       (wr_pd),
        .irq_pending (irq_pending),
        .ext_rst     (ext_rst),
        .rst_done    (rst_done),
        .clk_en      (clk_en),
        .int_rst     (int_rst),
        .ram_block   (ram_block),
        .wake        (wake),
        .set_idle    (set_idle),
        .set_pd      (set_pd),
        .clr_idle    (clr_idle),
        .clr_all     (clr_all)
    );

    lpm_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_idle (set_idle),
        .set_pd   (set_pd),
        .clr_idle (clr_idle),
        .clr_all  (clr_all),
        .idle_bit (idle_bit),
        .pd_bit   (pd_bit)
    );

    assign cpu_clk_en    = clk_en.cpu;
    assign periph_clk_en = clk_en.periph;
    assign osc_en        = clk_en.osc;

    a_r5_pd_ignores_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_bit && !ext_rst) |=> (!osc_en && pd_bit));

    a_r4_wake_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(!cpu_clk_en) && cpu_clk_en && !idle_bit));

    a_r4_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    a_r7_bits_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst |-> (!idle_bit && !pd_bit));

    a_r11_block_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ram_block |-> (int_rst || $past(ext_rst)));

    a_r2_idle_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_bit && !ram_block) |-> (!cpu_clk_en && periph_clk_en && osc_en));

endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;

    localparam int MC = 4;
    localparam int MCS = 2;
    localparam int T = MC * MCS;

    logic clk = 1'b0;
    logic rst_n, pcon_we, wr_idle, wr_pd, irq_pending, ext_rst;
    logic cpu_clk_en, periph_clk_en, osc_en, int_rst, ram_block, wake, idle_bit, pd_bit;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lpm_ctrl #(.MC_CLKS(MC), .RST_MCS(MCS)) dut (
        .clk(clk), .rst_n(rst_n), .pcon_we(pcon_we), .wr_idle(wr_idle), .wr_pd(wr_pd),
        .irq_pending(irq_pending), .ext_rst(ext_rst),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
        .int_rst(int_rst), .ram_block(ram_block), .wake(wake),
        .idle_bit(idle_bit), .pd_bit(pd_bit)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic init();
        rst_n = 1'b0; pcon_we = 1'b0; wr_idle = 1'b0; wr_pd = 1'b0;
        irq_pending = 1'b0; ext_rst = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic write_pcon(input logic i, input logic p);
        pcon_we = 1'b1; wr_idle = i; wr_pd = p;
        step();
        pcon_we = 1'b0; wr_idle = 1'b0; wr_pd = 1'b0;
    endtask

    // mode: 0 RUN, 1 IDLE, 2 PDOWN
    task automatic sweep_pulse(input int mode, input int n);
        init();
        if (mode == 1) write_pcon(1'b1, 1'b0);
        if (mode == 2) write_pcon(1'b0, 1'b1);
        ext_rst = 1'b1;
        for (int k = 1; k <= n; k++) begin
            step();
            chk("R6 int_rst during pulse", int'(int_rst), (k >= T) ? 1 : 0);
            if (mode == 1) begin
                chk("R9 ram_block while pin held in idle", int'(ram_block), 1);
                chk("R9 cpu clock while pin held in idle", int'(cpu_clk_en), 1);
            end
            if (mode == 2 && k < T) chk("R8 osc stays off before qualify", int'(osc_en), 0);
            if (mode == 0 && k < T) chk("R11 no block in RUN", int'(ram_block), 0);
            if (k >= T) begin
                chk("R11 block during int_rst", int'(ram_block), 1);
                chk("R7 bits clear during int_rst", int'({idle_bit, pd_bit}), 0);
                chk("R8 osc on in reset", int'(osc_en), 1);
            end
        end
        ext_rst = 1'b0;
        step();
        chk("R7 int_rst released", int'(int_rst), 0);
        if (n >= T || mode == 0) begin
            chk("R7 back to RUN clocks", int'({cpu_clk_en, periph_clk_en, osc_en}), 7);
            chk("R7 RUN bits", int'({idle_bit, pd_bit}), (n >= T) ? 0 : 0);
        end else if (mode == 1) begin
            chk("R9 short pulse returns idle", int'({cpu_clk_en, ram_block, idle_bit}), 1);
        end else begin
            chk("R8 short pulse keeps pdown", int'({osc_en, pd_bit}), 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        init();
        // R1 reset state
        chk("R1 clocks", int'({cpu_clk_en, periph_clk_en, osc_en}), 7);
        chk("R1 int_rst/ram_block/wake", int'({int_rst, ram_block, wake}), 0);
        chk("R1 bits", int'({idle_bit, pd_bit}), 0);

        // R2 idle entry, R4 interrupt exit
        write_pcon(1'b1, 1'b0);
        chk("R2 idle clocks", int'({cpu_clk_en, periph_clk_en, osc_en}), 3);
        chk("R2 idle bit", int'(idle_bit), 1);
        step();
        chk("R2 idle holds", int'(cpu_clk_en), 0);
        irq_pending = 1'b1;
        step();
        irq_pending = 1'b0;
        chk("R4 cpu restarts", int'(cpu_clk_en), 1);
        chk("R4 idle bit cleared", int'(idle_bit), 0);
        chk("R4 wake strobe", int'(wake), 1);
        step();
        chk("R4 wake one cycle", int'(wake), 0);

        // R9 interrupt ignored while pin held in idle
        write_pcon(1'b1, 1'b0);
        ext_rst = 1'b1; irq_pending = 1'b1;
        step(); step();
        chk("R9 irq ignored while held", int'({wake, idle_bit, ram_block}), 3);
        ext_rst = 1'b0; irq_pending = 1'b0;
        step();
        chk("R9 back to idle", int'({cpu_clk_en, ram_block, idle_bit}), 1);

        // R3 power-down with both bits, R5, R10
        init();
        write_pcon(1'b1, 1'b1);
        chk("R3 pd clocks off", int'({cpu_clk_en, periph_clk_en, osc_en}), 0);
        chk("R3 pd wins over idle", int'({idle_bit, pd_bit}), 1);
        irq_pending = 1'b1;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R5 irq ignored in pdown", int'({osc_en, cpu_clk_en, pd_bit}), 1);
        end
        irq_pending = 1'b0;
        write_pcon(1'b1, 1'b0);
        step();
        chk("R10 write ignored in pdown", int'({idle_bit, pd_bit, cpu_clk_en}), 2);

        // R6 counter restart: two sub-threshold pulses split by one low cycle
        init();
        ext_rst = 1'b1;
        for (int k = 0; k < T - 1; k++) begin
            step();
            chk("R6 first short pulse", int'(int_rst), 0);
        end
        ext_rst = 1'b0;
        step();
        ext_rst = 1'b1;
        for (int k = 0; k < T - 1; k++) begin
            step();
            chk("R6 restarted count", int'(int_rst), 0);
        end
        step();
        chk("R6 qualifies after full window", int'(int_rst), 1);
        ext_rst = 1'b0;
        step();

        // Sweep of pulse lengths from every resting state
        for (int m = 0; m < 3; m++) begin
            for (int n = 1; n <= T + 2; n++) begin
                sweep_pulse(m, n);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule